// File: doc/BRIEF.md
# Two-Phase Dual-Rail Pipelined Look-Ahead Adder

An 8-bit adder built as six half-cycle pipeline stages. Each stage carries every signal as a true/complement rail pair and returns to zero between evaluations. The two phases come from a single edge clock `clk_i` and a phase register that toggles on every edge. Odd stages evaluate while `phase_o` is low and discharge while it is high. Even stages do the opposite. One full cycle is two `clk_i` periods. A stage captures its predecessor's rails on the same edge at which the predecessor discharges, so data moves forward before the predecessor's rails fall to null.

Operands arrive as plain binary words with a valid flag and are converted to dual rail on capture. Stage one forms per-bit generate and propagate terms. The next three stages combine them in a parallel-prefix carry network over distances 1, 2 and 4. The fifth stage forms the sum rails and the sixth holds sum and carry-out. A single-rail output register decodes the result. A rail monitor on the last stage raises `error_o` on any illegal rail pattern.

Top module: `dr_cla_pipe`

## Requirements
- R1: When a valid pair is captured, `{cout_o, sum_o}` later equals the 9-bit sum `a_i + b_i`.
- R2: Operands are captured on the rising edge of `clk_i` at which `phase_o` is 1. Their result and `valid_o` appear at the sixth rising edge after that one (three full cycles). The outputs then stay unchanged for two `clk_i` periods.
- R3: A new operand pair may be captured every full cycle. Results emerge one per full cycle in capture order.
- R4: `phase_o` is 0 after reset and inverts on every rising edge. Values on `valid_i`, `a_i` and `b_i` at an edge where `phase_o` is 0 are ignored.
- R5: A capture with `valid_i` = 0 yields `valid_o` = 0. Whenever `valid_o` is 0, `sum_o` and `cout_o` are 0.
- R6: In every stage, a pair never has both rails at 1. A stage holding valid data has exactly one rail high per pair. A discharging or invalid stage has all rails at 0. `error_o` is 1 for one cycle after the last stage breaks any of these, and is 0 otherwise.
- R7: `rst_ni` low asynchronously clears `valid_o`, `sum_o`, `cout_o`, `error_o` and `phase_o`, and nulls every stage. Operands captured before the reset never reach the outputs.
- R8: Carries are formed by a look-ahead prefix network. A carry generated at bit 0 reaches `cout_o` within the same latency as any other result, for example 0xFF + 0x01 gives sum 0x00 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Edge clock, two periods per full cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand pair valid, sampled when `phase_o` is 1 |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| phase_o | output | 1 | Current phase; 1 in the cycle whose closing edge captures operands |
| valid_o | output | 1 | Result valid |
| sum_o | output | 8 | Sum, zero when not valid |
| cout_o | output | 1 | Carry-out, zero when not valid |
| error_o | output | 1 | Rail-code violation seen on the last stage |

## Verification
The hardest situation to reach from the ports is the proof that only one edge in two samples the operands. The off-phase input values must leave no trace, while back-to-back captures still land in consecutive full cycles. Each scenario therefore aligns to `phase_o` and drives a real operand before every capturing edge. Before every non-capturing edge it drives a valid-flagged junk pair. Every output is checked at both clock periods of each result. A reset pulse raised while an operand is in flight shows that partly evaluated rails are flushed.

// File: rtl/dr_cla_pkg.sv
`timescale 1ns/1ps
package dr_cla_pkg;
  localparam int unsigned DATA_W = 8;
endpackage

// File: rtl/dr_reg.sv
`timescale 1ns/1ps
// Return-to-zero dual-rail stage register: loads on cap_i, nulls on clr_i.
module dr_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         clr_i,
  input  logic         v_i,
  input  logic [N-1:0] t_i,
  input  logic [N-1:0] f_i,
  output logic         v_o,
  output logic [N-1:0] t_o,
  output logic [N-1:0] f_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      t_o <= '0;
      f_o <= '0;
    end else if (cap_i) begin
      v_o <= v_i;
      t_o <= t_i;
      f_o <= f_i;
    end else if (clr_i) begin
      v_o <= 1'b0;
      t_o <= '0;
      f_o <= '0;
    end
  end

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_o & f_o) == '0);
  p_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> &(t_o ^ f_o));
  p_null_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_o |-> ((t_o | f_o) == '0));
  p_rtz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cap_i) |=> (!v_o && t_o == '0 && f_o == '0));
endmodule

// File: rtl/dr_prefix.sv
`timescale 1ns/1ps
// One dual-rail prefix level: combines (G,P) at bit i with bit i-DIST.
module dr_prefix #(
  parameter int unsigned W    = 8,
  parameter int unsigned DIST = 1
) (
  input  logic [W-1:0] gt_i,
  input  logic [W-1:0] gf_i,
  input  logic [W-1:0] pt_i,
  input  logic [W-1:0] pf_i,
  output logic [W-1:0] gt_o,
  output logic [W-1:0] gf_o,
  output logic [W-1:0] pt_o,
  output logic [W-1:0] pf_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= DIST) begin : g_comb
      assign gt_o[i] = gt_i[i] | (pt_i[i] & gt_i[i-DIST]);
      assign gf_o[i] = gf_i[i] & (pf_i[i] | gf_i[i-DIST]);
      assign pt_o[i] = pt_i[i] & pt_i[i-DIST];
      assign pf_o[i] = pf_i[i] | pf_i[i-DIST];
    end else begin : g_pass
      assign gt_o[i] = gt_i[i];
      assign gf_o[i] = gf_i[i];
      assign pt_o[i] = pt_i[i];
      assign pf_o[i] = pf_i[i];
    end
  end
endmodule

// File: rtl/dr_sum.sv
`timescale 1ns/1ps
// Dual-rail sum: bit propagate XOR incoming carry; carry-out from top group.
module dr_sum #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pbt_i,
  input  logic [W-1:0] pbf_i,
  input  logic [W-1:0] gt_i,
  input  logic [W-1:0] gf_i,
  output logic [W:0]   st_o,
  output logic [W:0]   sf_o
);
  logic [W-1:0] ct, cf;

  // carry-in zero, but kept null-preserving via the rails of bit 0
  assign ct = {gt_i[W-2:0], 1'b0};
  assign cf = {gf_i[W-2:0], pbt_i[0] | pbf_i[0]};

  assign st_o[W-1:0] = (pbt_i & cf) | (pbf_i & ct);
  assign sf_o[W-1:0] = (pbt_i & ct) | (pbf_i & cf);
  assign st_o[W]     = gt_i[W-1];
  assign sf_o[W]     = gf_i[W-1];
endmodule

// File: rtl/dr_cla_pipe.sv
`timescale 1ns/1ps
module dr_cla_pipe
  import dr_cla_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         phase_o,
  output logic         valid_o,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         error_o
);
  localparam int unsigned LEVELS   = $clog2(W);
  localparam int unsigned PW       = 3 * W;
  localparam int unsigned SUM_STG  = LEVELS + 2;
  localparam bit          SUM_ODD  = (SUM_STG % 2) == 1;

  logic ph;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph <= 1'b0;
    else         ph <= ~ph;
  end
  assign phase_o = ph;

  // odd stages load when ph=1 at the edge, even stages when ph=0
  logic cap_odd, cap_even;
  assign cap_odd  = ph;
  assign cap_even = ~ph;

  // stage 1: encode to dual rail, generate and propagate
  logic [2*W-1:0] s1_ti, s1_fi, s1_t, s1_f;
  logic           s1_v;
  assign s1_ti = valid_i ? {a_i ^ b_i, a_i & b_i}       : '0;
  assign s1_fi = valid_i ? {~(a_i ^ b_i), ~(a_i & b_i)} : '0;

  dr_reg #(.N(2*W)) u_s1 (
    .clk_i, .rst_ni, .cap_i(cap_odd), .clr_i(cap_even),
    .v_i(valid_i), .t_i(s1_ti), .f_i(s1_fi),
    .v_o(s1_v), .t_o(s1_t), .f_o(s1_f)
  );

  // prefix levels: payload {bit propagate, group G, group P}
  logic [PW-1:0] lt [LEVELS+1];
  logic [PW-1:0] lf [LEVELS+1];
  logic          lv [LEVELS+1];

  assign lt[0] = {s1_t[2*W-1:W], s1_t[W-1:0], s1_t[2*W-1:W]};
  assign lf[0] = {s1_f[2*W-1:W], s1_f[W-1:0], s1_f[2*W-1:W]};
  assign lv[0] = s1_v;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
    localparam bit STG_EVEN = ((lvl + 2) % 2) == 0;
    logic [W-1:0] gt, gf, pt, pf;
    logic         cap, clr;

    assign cap = STG_EVEN ? cap_even : cap_odd;
    assign clr = ~cap;

    dr_prefix #(.W(W), .DIST(1 << lvl)) u_pfx (
      .gt_i(lt[lvl][2*W-1:W]), .gf_i(lf[lvl][2*W-1:W]),
      .pt_i(lt[lvl][W-1:0]),   .pf_i(lf[lvl][W-1:0]),
      .gt_o(gt), .gf_o(gf), .pt_o(pt), .pf_o(pf)
    );

    dr_reg #(.N(PW)) u_stg (
      .clk_i, .rst_ni, .cap_i(cap), .clr_i(clr),
      .v_i(lv[lvl]),
      .t_i({lt[lvl][PW-1:2*W], gt, pt}),
      .f_i({lf[lvl][PW-1:2*W], gf, pf}),
      .v_o(lv[lvl+1]), .t_o(lt[lvl+1]), .f_o(lf[lvl+1])
    );
  end

  // sum stage and output stage
  logic [W:0] sm_t, sm_f, s5_t, s5_f, s6_t, s6_f;
  logic       s5_v, s6_v, cap5, cap6;

  assign cap5 = SUM_ODD ? cap_odd : cap_even;
  assign cap6 = ~cap5;

  dr_sum #(.W(W)) u_sum (
    .pbt_i(lt[LEVELS][PW-1:2*W]), .pbf_i(lf[LEVELS][PW-1:2*W]),
    .gt_i(lt[LEVELS][2*W-1:W]),   .gf_i(lf[LEVELS][2*W-1:W]),
    .st_o(sm_t), .sf_o(sm_f)
  );

  dr_reg #(.N(W+1)) u_s5 (
    .clk_i, .rst_ni, .cap_i(cap5), .clr_i(cap6),
    .v_i(lv[LEVELS]), .t_i(sm_t), .f_i(sm_f),
    .v_o(s5_v), .t_o(s5_t), .f_o(s5_f)
  );

  dr_reg #(.N(W+1)) u_s6 (
    .clk_i, .rst_ni, .cap_i(cap6), .clr_i(cap5),
    .v_i(s5_v), .t_i(s5_t), .f_i(s5_f),
    .v_o(s6_v), .t_o(s6_t), .f_o(s6_f)
  );

  // single-rail decode, taken while the last stage evaluates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      cout_o  <= 1'b0;
    end else if (cap5) begin
      valid_o <= s6_v;
      sum_o   <= s6_v ? s6_t[W-1:0] : '0;
      cout_o  <= s6_v & s6_t[W];
    end
  end

  // rail monitor on the last stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) error_o <= 1'b0;
    else error_o <= (|(s6_t & s6_f))
                  | (s6_v & ~&(s6_t | s6_f))
                  | (~s6_v & |(s6_t | s6_f));
  end

  p_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_o != $past(phase_o)));
  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (sum_o == '0 && !cout_o));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap5 |=> $stable({valid_o, sum_o, cout_o}));
  p_noerr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !error_o);
endmodule

// File: tb/sim_dr_cla_pipe.sv
`timescale 1ns/1ps
module sim_dr_cla_pipe;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       phase_o, valid_o, cout_o, error_o;
  logic [7:0] sum_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] qa [8];
  logic [7:0] qb [8];
  logic       qv [8];

  always #2.5 clk_i = ~clk_i;

  dr_cla_pipe u0 (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i,
    .phase_o, .valid_o, .sum_o, .cout_o, .error_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk_i);
    while (phase_o !== 1'b1) @(negedge clk_i);
  endtask

  // drives n queued ops on capture edges, junk on the others, checks all outputs
  task automatic run_ops(input int n, input string req);
    logic [8:0] e;
    align();
    for (int s = 0; s <= 2*n + 6; s++) begin
      chk(phase_o == ((s % 2) == 0), "R4", "phase", phase_o, (s % 2) == 0);
      chk(error_o == 1'b0, "R6", "error_o", error_o, 0);
      if (s >= 7) begin
        int k = (s - 7) / 2;
        e = qv[k] ? ({1'b0, qa[k]} + {1'b0, qb[k]}) : 9'd0;
        chk(valid_o == qv[k], req, "valid_o", valid_o, qv[k]);
        chk({cout_o, sum_o} == e, req, "cout,sum", {cout_o, sum_o}, e);
      end
      if ((s % 2) == 0 && (s / 2) < n) begin
        valid_i = qv[s/2]; a_i = qa[s/2]; b_i = qb[s/2];
      end else if ((s % 2) == 1) begin
        valid_i = 1'b1; a_i = 8'hA5 ^ 8'(s); b_i = 8'h3C + 8'(s); // R4 junk
      end else begin
        valid_i = 1'b0; a_i = 8'h5A; b_i = 8'hC3;
      end
      @(negedge clk_i);
    end
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(valid_o == 1'b0 && sum_o == 8'h00 && cout_o == 1'b0, "R7", "outs in reset",
        {valid_o, cout_o, sum_o}, 0);
    chk(phase_o == 1'b0 && error_o == 1'b0, "R7", "phase/err in reset",
        {phase_o, error_o}, 0);
  endtask

  task automatic t_basic();  // R1 R2
    qa[0] = 8'h03; qb[0] = 8'h05; qv[0] = 1;
    qa[1] = 8'h7F; qb[1] = 8'h01; qv[1] = 1;
    qa[2] = 8'hFF; qb[2] = 8'hFF; qv[2] = 1;
    qa[3] = 8'h00; qb[3] = 8'h00; qv[3] = 1;
    run_ops(4, "R1/R2");
  endtask

  task automatic t_carry();  // R8
    qa[0] = 8'hFF; qb[0] = 8'h01; qv[0] = 1;
    qa[1] = 8'h80; qb[1] = 8'h80; qv[1] = 1;
    qa[2] = 8'h55; qb[2] = 8'hAA; qv[2] = 1;
    qa[3] = 8'hAA; qb[3] = 8'h56; qv[3] = 1;
    qa[4] = 8'h0F; qb[4] = 8'hF1; qv[4] = 1;
    run_ops(5, "R8");
  endtask

  task automatic t_stream();  // R3
    for (int k = 0; k < 8; k++) begin
      qa[k] = 8'(k * 37 + 11); qb[k] = 8'(k * 91 + 200); qv[k] = 1;
    end
    run_ops(8, "R3");
  endtask

  task automatic t_bubble();  // R5
    for (int k = 0; k < 6; k++) begin
      qa[k] = 8'(k * 53 + 7); qb[k] = 8'(255 - k * 19); qv[k] = (k % 2) == 0;
    end
    run_ops(6, "R5");
  endtask

  task automatic t_midreset();  // R7
    align();
    valid_i = 1'b1; a_i = 8'h12; b_i = 8'h34;
    @(negedge clk_i);
    valid_i = 1'b1; a_i = 8'h99; b_i = 8'h88;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0 && phase_o == 1'b0 && error_o == 1'b0, "R7", "async clear",
        {valid_o, phase_o, error_o}, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int s = 0; s < 12; s++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0 && sum_o == 8'h00 && cout_o == 1'b0, "R7", "flushed op",
          {valid_o, cout_o, sum_o}, 0);
    end
    qa[0] = 8'hC8; qb[0] = 8'h64; qv[0] = 1;
    run_ops(1, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_basic();
    t_carry();
    t_stream();
    t_bubble();
    t_midreset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule